// File: doc/BRIEF.md
# Memory-Type-Aware Store Buffer

This block sits between a processor load/store port and a simple valid/ready memory bus. It queues writes and retires them to the bus in the background. Every access carries a memory-type tag: Normal, Device or Strongly Ordered. Normal and Device accesses also carry a shared flag, and Normal accesses carry a cacheability code. Writes to Normal and Device memory enter a small FIFO and are acknowledged at once. Reads and Strongly Ordered accesses go straight to the bus, but only when the ordering rule for their type allows it. Until then the block holds the core with `core_ready` low.

A Strongly Ordered access, read or write, waits until the buffer is completely empty. A Device read waits only until no Device-tagged write remains queued, which is judged from a dedicated Device occupancy counter. A Normal read goes ahead of queued writes unless it targets the same word as a queued Normal write. When a read is eligible in the same cycle as a queued write, the read takes the bus. The block also computes a cacheable hint for the L1 from the attributes of the access currently presented.

Top module: `ordered_store_buffer`

## Requirements
- R1: `req_mtype` encodes the memory type: 00 is Normal, 01 is Device, and 10 or 11 is Strongly Ordered. `req_cache` encodes cacheability for Normal accesses: 00 is non-cacheable, 01 is write-through and 10 is write-back.
- R2: A Normal or Device write presented while fewer than DEPTH entries are queued is accepted in the same cycle (`core_ready`=1). Queued writes appear on the bus as writes in the order they were accepted. One entry retires per cycle in which `bus_valid` and `bus_ready` are both high.
- R3: A Strongly Ordered read or write is not put on the bus while any entry is queued. Once the buffer is empty, it is driven directly on the bus and accepted in the cycle of its bus handshake.
- R4: A Device read is not put on the bus while any Device write is queued. Queued Normal writes do not hold it back.
- R5: A Normal read that matches no queued Normal write is driven on the bus at once. If a queued write is pending in the same cycle, the read takes the bus and the queued write waits.
- R6: A Normal read whose word address (`req_addr[AW-1:2]`) equals that of a queued Normal write is stalled until that write has retired.
- R7: In the cycle a read is accepted, `core_rdata` equals `bus_rdata`.
- R8: A Normal or Device write presented while DEPTH entries are queued is not accepted (`core_ready`=0).
- R9: `l1_cacheable` is 1 exactly when a request is presented with type Normal, `req_shared`=0 and `req_cache` not 00.
- R10: After reset the buffer is empty: `bus_valid` is 0 with no request presented, and DEPTH writes are accepted before the first stall.
- R11: `bus_shared` carries the `req_shared` value stored or presented with a Normal or Device access. It is forced to 1 for a Strongly Ordered access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core access request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| req_strb | input | DW/8 | Write byte strobes |
| req_mtype | input | 2 | Memory type (R1) |
| req_shared | input | 1 | Shared attribute |
| req_cache | input | 2 | Normal cacheability (R1) |
| core_ready | output | 1 | Access accepted this cycle |
| core_rdata | output | DW | Read data for an accepted read |
| l1_cacheable | output | 1 | Cacheable hint for the L1 |
| bus_valid | output | 1 | Bus request present |
| bus_ready | input | 1 | Bus accepts request this cycle |
| bus_write | output | 1 | Bus request is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_strb | output | DW/8 | Bus byte strobes |
| bus_shared | output | 1 | Shared attribute of the bus request |
| bus_rdata | input | DW | Bus read data |

## Verification
Two pairs of functions can fall in the same cycle. First, a read can become eligible while the head write is offered to the bus, and the read must win. Second, a new write can be enqueued in the cycle the head retires. The bench provokes both with a mixed stream of all three types over only eight word addresses, under a bus that stalls at random, and it starts with a phase in which the bus never accepts so that the buffer fills. A behavioural queue model predicts the request, data, shared flag, acknowledge and hint on every cycle. The bench separately confirms that no Device read or Strongly Ordered access is accepted while the model still holds a conflicting write.

// File: rtl/ordered_store_buffer.sv
module ordered_store_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_strb,
  input  logic [1:0]      req_mtype,
  input  logic            req_shared,
  input  logic [1:0]      req_cache,
  output logic            core_ready,
  output logic [DW-1:0]   core_rdata,
  output logic            l1_cacheable,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic            bus_write,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [DW/8-1:0] bus_strb,
  output logic            bus_shared,
  input  logic [DW-1:0]   bus_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]   e_addr [DEPTH];
  logic [DW-1:0]   e_data [DEPTH];
  logic [DW/8-1:0] e_strb [DEPTH];
  logic [DEPTH-1:0] vld, e_dev, e_shr, match;
  logic [PW-1:0]   rp, wp;
  logic [CW-1:0]   cnt, dev_cnt;

  wire is_so   = req_mtype[1];
  wire is_dev  = (req_mtype == 2'b01);
  wire is_norm = (req_mtype == 2'b00);
  wire empty   = (cnt == '0);
  wire full    = (cnt == CW'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] & ~e_dev[i] & (e_addr[i][AW-1:2] == req_addr[AW-1:2]);
  end

  wire rd_go  = req_valid & ~req_write &
                (is_so ? empty : (is_dev ? (dev_cnt == '0) : ~|match));
  wire so_wr  = req_valid & req_write & is_so & empty;
  wire direct = rd_go | so_wr;
  wire enq    = req_valid & req_write & ~is_so & ~full;
  wire retire = ~empty & ~direct & bus_ready;

  assign bus_valid  = direct | ~empty;
  assign bus_write  = direct ? req_write : 1'b1;
  assign bus_addr   = direct ? req_addr  : e_addr[rp];
  assign bus_wdata  = direct ? req_wdata : e_data[rp];
  assign bus_strb   = direct ? req_strb  : e_strb[rp];
  assign bus_shared = direct ? (is_so | req_shared) : e_shr[rp];

  assign core_ready   = enq | (direct & bus_ready);
  assign core_rdata   = bus_rdata;
  assign l1_cacheable = req_valid & is_norm & ~req_shared & (req_cache != 2'b00);

  always_ff @(posedge clk) begin
    if (enq) begin
      e_addr[wp] <= req_addr;
      e_data[wp] <= req_wdata;
      e_strb[wp] <= req_strb;
      e_dev[wp]  <= is_dev;
      e_shr[wp]  <= req_shared;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= '0;
      rp      <= '0;
      wp      <= '0;
      cnt     <= '0;
      dev_cnt <= '0;
    end else begin
      if (enq) begin
        vld[wp] <= 1'b1;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (retire) begin
        vld[rp] <= 1'b0;
        rp      <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      cnt     <= cnt + CW'(enq) - CW'(retire);
      dev_cnt <= dev_cnt + CW'(enq & is_dev) - CW'(retire & e_dev[rp]);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r4_dev_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cnt <= cnt);
  a_r2_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == int'(cnt));
  a_r3_so_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_so && core_ready) |-> (cnt == '0));
  a_r4_dev_read_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && is_dev && core_ready) |-> (dev_cnt == '0));
  a_r8_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (full && req_valid && req_write && !is_so) |-> !core_ready);
  a_r9_hint_normal: assert property (@(posedge clk) disable iff (!rst_n)
    l1_cacheable |-> (req_valid && is_norm && !req_shared));
endmodule

// File: tb/tb_ordered_store_buffer.sv
`timescale 1ns/100ps
module tb_ordered_store_buffer;
  localparam int AW = 32, DW = 32, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_shared = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0] req_strb = '0;
  logic [1:0] req_mtype = '0, req_cache = '0;
  logic core_ready, l1_cacheable, bus_valid, bus_write, bus_shared;
  logic bus_ready = 0;
  logic [DW-1:0] core_rdata, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_strb;

  always #2.5 clk = ~clk;
  assign bus_rdata = ~bus_addr;

  ordered_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .req_mtype(req_mtype), .req_shared(req_shared), .req_cache(req_cache),
    .core_ready(core_ready), .core_rdata(core_rdata), .l1_cacheable(l1_cacheable),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
    .bus_shared(bus_shared), .bus_rdata(bus_rdata));

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [3:0]    strb;
    bit            dev;
    bit            shr;
  } ent_t;

  ent_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int dev_in_q();
    int n = 0;
    foreach (q[i]) if (q[i].dev) n++;
    return n;
  endfunction

  function automatic bit hit_q(input logic [AW-1:0] a);
    foreach (q[i]) if (!q[i].dev && q[i].addr[AW-1:2] == a[AW-1:2]) return 1;
    return 0;
  endfunction

  task automatic pick();
    int t = $urandom % 10;
    req_valid = 1;
    req_write = ($urandom % 10) < 6;
    req_mtype = (t < 5) ? 2'b00 : (t < 8) ? 2'b01 : ((t == 8) ? 2'b10 : 2'b11);
    req_addr  = 32'h1000 + (($urandom % 8) << 2) + ($urandom % 4);
    req_wdata = $urandom;
    req_strb  = 4'($urandom);
    req_shared = $urandom % 2;
    req_cache = 2'($urandom % 3);
  endtask

  task automatic do_reset();
    req_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 reset bus_valid", 32'(bus_valid), 0);
    q.delete();
    rst_n = 1;
  endtask

  initial begin
    bit have = 0;
    do_reset();
    for (int cyc = 0; cyc < 6000; cyc++) begin
      bit so, dv, nm, hit, rd_go, direct, enq, exp_ready, exp_valid;
      @(negedge clk);
      if (cyc == 3000) begin
        do_reset();
        have = 0;
        @(negedge clk);
      end
      if (!have) begin
        if (cyc < 30) begin
          pick();
          req_write = 1;
          req_mtype = 2'b00;
          have = 1;
        end else if (($urandom % 4) != 0) begin
          pick();
          have = 1;
        end else
          req_valid = 0;
      end
      bus_ready = (cyc < 30) ? 1'b0 : (($urandom % 4) != 0);
      #1;
      so = req_mtype[1];
      dv = (req_mtype == 2'b01);
      nm = (req_mtype == 2'b00);
      hit = hit_q(req_addr);
      rd_go = req_valid && !req_write &&
              (so ? (q.size() == 0) : (dv ? (dev_in_q() == 0) : !hit));
      direct = rd_go || (req_valid && req_write && so && q.size() == 0);
      enq = req_valid && req_write && !so && q.size() < DEPTH;
      exp_ready = enq || (direct && bus_ready);
      exp_valid = direct || q.size() > 0;

      if (!req_valid) chk("R10 R2 bus_valid", 32'(bus_valid), 32'(exp_valid));
      else if (so) chk("R3 core_ready", 32'(core_ready), 32'(exp_ready));
      else if (req_write) chk("R8 core_ready", 32'(core_ready), 32'(exp_ready));
      else if (dv) chk("R4 core_ready", 32'(core_ready), 32'(exp_ready));
      else chk("R6 core_ready", 32'(core_ready), 32'(exp_ready));
      chk("R2 bus_valid", 32'(bus_valid), 32'(exp_valid));
      chk("R1 R9 l1_cacheable", 32'(l1_cacheable),
          32'(req_valid && nm && !req_shared && req_cache != 2'b00));
      if (direct) begin
        chk("R5 bus_write", 32'(bus_write), 32'(req_write));
        chk("R5 bus_addr", bus_addr, req_addr);
        chk("R11 bus_shared", 32'(bus_shared), 32'(so | req_shared));
        if (req_write) chk("R3 bus_wdata", bus_wdata, req_wdata);
        if (!req_write && bus_ready) chk("R7 core_rdata", core_rdata, ~req_addr);
        if (bus_ready && so) chk("R3 buffer empty", q.size(), 0);
        if (bus_ready && dv && !req_write) chk("R4 no device write queued", dev_in_q(), 0);
        if (bus_ready && nm && !req_write) chk("R6 no matching write", 32'(hit), 0);
      end else if (q.size() > 0) begin
        chk("R2 bus_write", 32'(bus_write), 1);
        chk("R2 bus_addr order", bus_addr, q[0].addr);
        chk("R2 bus_wdata order", bus_wdata, q[0].data);
        chk("R2 bus_strb", 32'(bus_strb), 32'(q[0].strb));
        chk("R11 bus_shared queued", 32'(bus_shared), 32'(q[0].shr));
      end

      if (!direct && q.size() > 0 && bus_ready) void'(q.pop_front());
      if (enq) q.push_back('{addr: req_addr, data: req_wdata, strb: req_strb,
                             dev: dv, shr: req_shared});
      if (exp_ready) have = 0;
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule